// File: doc/BRIEF.md
# Ancillary Packet Deleter

This block sits inline on a 10-bit digital video word stream. Every word is registered on the rising edge of the pixel clock. When packet removal is switched on, any ancillary data packet whose data identifier matches one of four programmed identifier values is blanked out. These values cover the audio, extended audio, arbitrary data and audio control identifiers. Every word of a removed packet is overwritten with a blanking level, so the output keeps the same word count and timing as the input. All other packets pass untouched, error-detection packets among them. Deleting packets leaves the checksums in those error-detection packets stale. The block does not recompute them.

A second switch blanks the four-word timing reference sequences in the same way. This is for 525/625 composite-style streams, where downstream equipment does not expect those words. Each switch is on when its dedicated pin is high, or when the register-select bit and the matching register bit are both high.

The block holds a short delay line of input words. A removal decision is taken when the first header word of a packet reaches the end of that line. By then the identifier and the data count have already been captured behind it.

Top module: `anc_pkt_deleter`

## Requirements
- R1: With no removal in progress, the word sampled on `vid_in` at a rising clock edge appears unchanged on `vid_out` after the sixth rising edge that follows it.
- R2: An ancillary packet is the words 0x000, 0x3FF, 0x3FF, then an identifier word, a secondary identifier word, a count word whose bits 7:0 give N, then N user words and one checksum word, for 7+N words in total. A removed packet is blanked through its checksum word, and the word after the checksum passes unchanged.
- R3: Packet removal is on when `anc_strip_pin` is high, or when both `cfg_sel` and `cfg_anc_strip` are high. While it is on, a packet whose identifier bits 7:0 equal any of `did_audio`, `did_audio_ext`, `did_arbitrary` or `did_audio_ctl` has all its words replaced.
- R4: A replaced word is 0x200 at chroma positions and 0x040 at luma positions. The first word of a timing reference sequence is a chroma position, and positions alternate on every word after it.
- R5: Identifier matching ignores bits 9:8 of the identifier word.
- R6: While removal is on, a packet whose identifier matches none of the four values passes unchanged. This includes an error-detection packet with identifier 0xF4.
- R7: While packet removal is off, every ancillary packet passes unchanged.
- R8: A timing reference sequence is 0x3FF, 0x000, 0x000 and one status word. Its four words are replaced when `trs_strip_pin` is high, or when both `cfg_sel` and `cfg_trs_strip` are high. Otherwise it passes unchanged.
- R9: While `cfg_sel` is low, `cfg_anc_strip` and `cfg_trs_strip` have no effect on the output.
- R10: While `rst_n` is low, `vid_out` is 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| vid_in | input | 10 | Incoming video word |
| anc_strip_pin | input | 1 | Pin enabling packet removal |
| trs_strip_pin | input | 1 | Pin enabling timing reference removal |
| cfg_sel | input | 1 | Register-select bit; when high, the two register enables below apply |
| cfg_anc_strip | input | 1 | Register enable for packet removal |
| cfg_trs_strip | input | 1 | Register enable for timing reference removal |
| did_audio | input | 8 | Audio identifier to remove |
| did_audio_ext | input | 8 | Extended audio identifier to remove |
| did_arbitrary | input | 8 | Arbitrary data identifier to remove |
| did_audio_ctl | input | 8 | Audio control identifier to remove |
| vid_out | output | 10 | Outgoing video word, six clocks behind the input |

## Verification
The stream is built from lines, each opening with a timing reference sequence followed by video fill and packets. Packets carry the four programmed identifiers, the error-detection identifier, or unrelated identifiers, each with random parity bits. Matching packets are blanked while the others survive, and varying the parity bits shows that they play no part in the match. Enable settings rotate across pin-driven, register-driven, register-bits-without-select and fully-off lines, so the blanking can be tied to the right enable path. Directed lines add zero-length and 255-word packets and packets placed back to back, which checks the exact end of each removal and the luma/chroma alternation across packet boundaries.

// File: rtl/anc_del_pkg.sv
package anc_del_pkg;
  localparam int VW = 10;
  localparam int DIDW = 8;
  localparam int DCW = 8;
  localparam int PKT_FIXED = 7;
  localparam logic [VW-1:0] WORD_LO = 10'h000;
  localparam logic [VW-1:0] WORD_HI = 10'h3FF;
  localparam logic [VW-1:0] BLANK_Y = 10'h040;
  localparam logic [VW-1:0] BLANK_C = 10'h200;
  typedef logic [VW-1:0] vword_t;
endpackage

// File: rtl/anc_delay_line.sv
module anc_delay_line
  import anc_del_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  vword_t                    din,
  output logic [DEPTH-1:0][VW-1:0]  taps
);
  logic [DEPTH-1:0][VW-1:0] stage_d;
  logic [DEPTH-1:0][VW-1:0] stage_q;

  always_comb begin
    stage_d = {stage_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign taps = stage_q;
endmodule

// File: rtl/anc_hdr_detect.sv
module anc_hdr_detect
  import anc_del_pkg::*;
#(
  parameter int DEPTH   = 6,
  parameter int NUM_DID = 4
) (
  input  logic [DEPTH-1:0][VW-1:0]     taps,
  input  logic [NUM_DID-1:0][DIDW-1:0] did_tab,
  output vword_t                       tail,
  output logic                         anc_hdr,
  output logic                         trs_hdr,
  output logic                         did_hit,
  output logic [DCW-1:0]               dcount
);
  localparam int T0  = DEPTH - 1;
  localparam int T1  = DEPTH - 2;
  localparam int T2  = DEPTH - 3;
  localparam int TID = DEPTH - 4;
  localparam int TDC = DEPTH - 6;

  logic [NUM_DID-1:0] hit_vec;
  vword_t             id_word;

  assign tail    = taps[T0];
  assign id_word = taps[TID];
  assign dcount  = taps[TDC][DCW-1:0];

  // one comparator per programmed identifier, parity bits left out
  for (genvar g = 0; g < NUM_DID; g++) begin : g_cmp
    assign hit_vec[g] = (id_word[DIDW-1:0] == did_tab[g]);
  end

  always_comb begin
    anc_hdr = (taps[T0] == WORD_LO) && (taps[T1] == WORD_HI) && (taps[T2] == WORD_HI);
    trs_hdr = (taps[T0] == WORD_HI) && (taps[T1] == WORD_LO) && (taps[T2] == WORD_LO);
    did_hit = |hit_vec;
  end
endmodule

// File: rtl/anc_del_ctrl.sv
module anc_del_ctrl
  import anc_del_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  vword_t         tail,
  input  logic           anc_hdr,
  input  logic           trs_hdr,
  input  logic           did_hit,
  input  logic [DCW-1:0] dcount,
  input  logic           anc_en,
  input  logic           trs_en,
  output vword_t         dout,
  output logic           busy
);
  localparam logic [CNT_W-1:0] TRS_REST = CNT_W'(3);
  localparam logic [CNT_W-1:0] PKT_REST = CNT_W'(PKT_FIXED - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             luma_q, luma_d, luma_cur;
  logic             anc_start, trs_start, del_now;
  vword_t           dout_q, dout_d;

  always_comb begin
    busy      = (cnt_q != '0);
    anc_start = anc_hdr && anc_en && did_hit && !busy;
    trs_start = trs_hdr && trs_en && !busy;
    del_now   = anc_start || trs_start || busy;
    luma_cur  = trs_hdr ? 1'b0 : luma_q;
    luma_d    = !luma_cur;
    if (anc_start)      cnt_d = CNT_W'(dcount) + PKT_REST;
    else if (trs_start) cnt_d = TRS_REST;
    else if (busy)      cnt_d = cnt_q - 1'b1;
    else                cnt_d = cnt_q;
    dout_d = del_now ? (luma_cur ? BLANK_Y : BLANK_C) : tail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      luma_q <= 1'b0;
      dout_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      luma_q <= luma_d;
      dout_q <= dout_d;
    end
  end

  assign dout = dout_q;

  AST_BLANK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    del_now |=> (dout == BLANK_Y || dout == BLANK_C)); // R4
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !anc_start && !trs_start) |=> (cnt_q == '0)); // R3
  AST_TRS_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (trs_hdr && trs_en && !busy) |=> (dout == BLANK_C)); // R8
endmodule

// File: rtl/anc_pkt_deleter.sv
module anc_pkt_deleter
  import anc_del_pkg::*;
#(
  parameter int DEPTH = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [9:0]      vid_in,
  input  logic            anc_strip_pin,
  input  logic            trs_strip_pin,
  input  logic            cfg_sel,
  input  logic            cfg_anc_strip,
  input  logic            cfg_trs_strip,
  input  logic [7:0]      did_audio,
  input  logic [7:0]      did_audio_ext,
  input  logic [7:0]      did_arbitrary,
  input  logic [7:0]      did_audio_ctl,
  output logic [9:0]      vid_out
);
  localparam int NUM_DID = 4;
  localparam int CNT_W   = $clog2(PKT_FIXED + (1 << DCW));

  logic [DEPTH-1:0][VW-1:0]     taps;
  logic [NUM_DID-1:0][DIDW-1:0] did_tab;
  vword_t                       tail;
  logic                         anc_hdr, trs_hdr, did_hit, busy;
  logic                         anc_en, trs_en;
  logic [DCW-1:0]               dcount;

  always_comb begin
    anc_en  = anc_strip_pin || (cfg_sel && cfg_anc_strip);
    trs_en  = trs_strip_pin || (cfg_sel && cfg_trs_strip);
    did_tab = {did_audio_ctl, did_arbitrary, did_audio_ext, did_audio};
  end

  anc_delay_line #(.DEPTH(DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_n), .din(vid_in), .taps(taps)
  );

  anc_hdr_detect #(.DEPTH(DEPTH), .NUM_DID(NUM_DID)) u_det (
    .taps(taps), .did_tab(did_tab), .tail(tail), .anc_hdr(anc_hdr),
    .trs_hdr(trs_hdr), .did_hit(did_hit), .dcount(dcount)
  );

  anc_del_ctrl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tail(tail), .anc_hdr(anc_hdr),
    .trs_hdr(trs_hdr), .did_hit(did_hit), .dcount(dcount),
    .anc_en(anc_en), .trs_en(trs_en), .dout(vid_out), .busy(busy)
  );

  AST_NONMATCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (anc_hdr && !busy && anc_en && !did_hit) |=> (vid_out == WORD_LO)); // R6
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (anc_hdr && !busy && !anc_en) |=> (vid_out == WORD_LO)); // R7
  AST_IDLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !anc_hdr && !trs_hdr) |=> (vid_out == $past(tail))); // R1
endmodule

// File: tb/sim_anc_pkt_deleter.sv
`timescale 1ns/1ps
module sim_anc_pkt_deleter;
  localparam int MAXW = 16384;
  localparam int LAT  = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic [9:0] vid_in, vid_out;
  logic anc_pin, trs_pin, sel, r_anc, r_trs;
  logic [7:0] dids [4];

  logic [9:0] stim [MAXW];
  logic [9:0] expw [MAXW];
  logic [4:0] cfgw [MAXW];
  int         tagw [MAXW];
  int nw, lpos, checks, fails;
  logic [4:0] cur_cfg;
  bit done;

  always #10 clk = ~clk;

  anc_pkt_deleter u0 (
    .clk(clk), .rst_n(rst_n), .vid_in(vid_in), .anc_strip_pin(anc_pin),
    .trs_strip_pin(trs_pin), .cfg_sel(sel), .cfg_anc_strip(r_anc),
    .cfg_trs_strip(r_trs), .did_audio(dids[0]), .did_audio_ext(dids[1]),
    .did_arbitrary(dids[2]), .did_audio_ctl(dids[3]), .vid_out(vid_out)
  );

  function automatic string tag_name(int c);
    case (c)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic logic [9:0] blank(int p);
    return p[0] ? 10'h040 : 10'h200;
  endfunction
  function automatic bit anc_on();
    return cur_cfg[0] || (cur_cfg[2] && cur_cfg[3]);
  endfunction
  function automatic bit trs_on();
    return cur_cfg[1] || (cur_cfg[2] && cur_cfg[4]);
  endfunction

  task automatic check(input logic [9:0] act, input logic [9:0] exp, input int tg);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: vid_out=%h expected %h", tag_name(tg), act, exp);
    end
  endtask

  task automatic emit(input logic [9:0] w, input bit del, input int tg);
    stim[nw] = w; expw[nw] = del ? blank(lpos) : w;
    cfgw[nw] = cur_cfg; tagw[nw] = tg; nw++; lpos++;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) emit(10'h040 + 10'($urandom % 32'h36C), 1'b0, 1);
  endtask

  task automatic line_start(input logic [4:0] cfg);
    int tg;
    cur_cfg = cfg; lpos = 0;
    tg = (!cfg[1] && !cfg[2] && cfg[4]) ? 9 : 8;   // R9 when bit set without select
    emit(10'h3FF, trs_on(), tg);
    emit(10'h000, trs_on(), tg);
    emit(10'h000, trs_on(), tg);
    emit(10'h200 | 10'($urandom % 256), trs_on(), 4);
    fill(8);
  endtask

  task automatic pkt(input logic [9:0] did, input int dc);
    bit del; int ptg, dtg;
    del = anc_on() && (did[7:0] == dids[0] || did[7:0] == dids[1] ||
                       did[7:0] == dids[2] || did[7:0] == dids[3]);
    ptg = anc_on() ? 6 : ((!cur_cfg[0] && !cur_cfg[2] && cur_cfg[3]) ? 9 : 7);
    dtg = (did[9:8] != 2'b01) ? 5 : 3;
    emit(10'h000, del, del ? dtg : ptg);
    emit(10'h3FF, del, del ? dtg : ptg);
    emit(10'h3FF, del, del ? dtg : ptg);
    emit(did, del, del ? dtg : ptg);
    emit(10'h100 + 10'($urandom % 512), del, del ? 4 : ptg);
    emit({2'b01, 8'(dc)}, del, del ? dtg : ptg);
    for (int k = 0; k < dc; k++) emit(10'h100 + 10'($urandom % 512), del, del ? 4 : ptg);
    emit(10'h100 + 10'($urandom % 512), del, del ? 2 : ptg);
    emit(10'h0A0, 1'b0, 2);   // word right after packet passes (R2)
  endtask

  task automatic rand_pkt(input int maxdc);
    int kind; logic [7:0] d;
    kind = $urandom % 7;
    if (kind < 4)       d = dids[kind];
    else if (kind == 4) d = 8'hF4;
    else                d = 8'h10 + 8'($urandom % 192);
    pkt({2'($urandom % 4), d}, $urandom % maxdc);
    fill($urandom % 3);
  endtask

  initial begin
    done = 1'b0;
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2468));
    checks = 0; fails = 0; nw = 0;
    dids[0] = 8'hE0; dids[1] = 8'hE4; dids[2] = 8'hE8; dids[3] = 8'hEC;
    // directed: pin path, zero and maximum lengths, back to back, error-detection packet
    line_start(5'b00011);
    pkt(10'h1E0, 0); pkt(10'h2E4, 255); pkt(10'h0E8, 3); pkt(10'h3EC, 1);
    pkt(10'h2F4, 4); fill(2); pkt(10'h155, 2); fill(8);
    // directed: everything off
    line_start(5'b00000);
    pkt(10'h1E0, 2); pkt(10'h3E4, 0); fill(8);
    // directed: register path with select
    line_start(5'b01100);
    pkt(10'h2E8, 5); pkt(10'h1F4, 1); fill(8);
    // directed: register bits without select (R9)
    line_start(5'b11000);
    pkt(10'h1EC, 3); pkt(10'h0E0, 0); fill(8);
    // constrained random lines
    for (int ln = 0; ln < 40; ln++) begin
      line_start(5'($urandom % 32));
      for (int p = 0; p < 1 + int'($urandom % 6); p++) rand_pkt(24);
      fill(8);
    end

    rst_n = 1'b0; vid_in = 10'h100;
    {r_trs, r_anc, sel, trs_pin, anc_pin} = 5'b0;
    repeat (3) @(negedge clk);
    check(vid_out, 10'h000, 10);   // R10
    vid_in = 10'h3FF;
    @(negedge clk);
    check(vid_out, 10'h000, 10);   // R10
    rst_n = 1'b1;

    for (int t = 0; t < nw + LAT + 1; t++) begin
      @(negedge clk);
      if (t >= LAT + 1) check(vid_out, expw[t-LAT-1], tagw[t-LAT-1]);
      if (t < nw) begin
        vid_in = stim[t];
        {r_trs, r_anc, sel, trs_pin, anc_pin} = cfgw[t];
      end else begin
        vid_in = 10'h150;
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule